// File: doc/BRIEF.md
# Message-Digest Context Register Front End

This block is the register-side front end of a message-digest engine. It sits between a 32-bit host register bus and a hash compression core that can run MD5, SHA-1, SHA-224 or SHA-256. It holds the hash context, which is five 32-bit chaining words (A to E) plus a 64-bit running message bit count. It also holds a mode register, with an algorithm field and a one-shot initialise command, and a data-size register that says how many bits of the last 512-bit block are meaningful. A write-only end-of-message trigger is also part of it. A host suspends a hash by reading the context back and resumes it later by writing the context in again.

MD5 keeps its state little-endian and the SHA family keeps it big-endian. The block therefore byte-reverses each chaining word inside its own 32 bits on both host writes and host reads, and only when MD5 is selected. The count words are never reversed. Reading the context while the engine has not finished returns zero and raises a one-cycle error pulse instead of stale data. The compression core is replaced by a stub that reports completion a fixed number of cycles after the trigger and adds the final-block bit count to the message length.

Top module: `hash_ctx_regs`

## Requirements
- R1: After reset the five chaining words, both count words, the algorithm field and the data-size register are all zero, and `done`, `err_irq` and `bus_rdata` are 0.
- R2: With a SHA algorithm selected, a host write of a chaining word (word addresses 4 to 8 for A to E) stores the bus value unchanged, and a later read returns it unchanged.
- R3: With MD5 selected (algorithm code 00), host writes and reads of words A to E are byte-reversed within each 32-bit word. The count words (address 9 for the low half, 10 for the high half) are never reversed.
- R4: A read of any context address (4 to 10) while `done` is 0 returns zero data and raises `err_irq` for exactly one cycle, aligned with the read data.
- R5: A read of a context address while `done` is 1 leaves `err_irq` at 0.
- R6: A write of any value to the end-of-message address (2) clears `done` at the next edge and starts the core. `done` rises exactly LATENCY cycles after the trigger edge and stays high until the next trigger.
- R7: A read of the end-of-message address returns zero and never raises `err_irq`.
- R8: A mode write with bit 2 set loads words A to E with the first five standard initial values of the algorithm in bits 1:0 of that same write, and clears the count. Bit 2 always reads back as 0.
- R9: The data-size register (address 1) takes the written value clamped to 512. When the core finishes, this value is added to the 64-bit count, with a carry from the low word into the high word.
- R10: The mode register (address 0) stores bits 1:0 as the algorithm (00 MD5, 01 SHA-1, 10 SHA-224, 11 SHA-256) and ignores every other written bit.
- R11: Read data is registered and appears the cycle after the read strobe. Reads of unmapped addresses (3, 11 to 15) return zero without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| err_irq | output | 1 | One-cycle illegal-context-read pulse |
| done | output | 1 | Core finished; held until next trigger |

## Verification
The hardest state to reach from the ports is a context read issued while the core is still counting toward completion. Only there does the error path compete with a valid context. The bench reaches it by firing the end-of-message trigger while `done` is already high and reading a chaining word in the next cycle, then waiting for completion and checking that the count grew by the clamped data size. The MD5 byte reversal is exposed by writing a word under one algorithm and reading it under another. This separates the write-side swap from the read-side swap, which a same-mode round trip would hide.

// File: rtl/hctx_pkg.sv
package hctx_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned HASH_WORDS = 5;
  localparam int unsigned CTX_WORDS  = HASH_WORDS + 2;
  localparam int unsigned ADDR_W     = 4;
  localparam int unsigned BLOCK_BITS = 512;
  localparam int unsigned DSIZE_W    = $clog2(BLOCK_BITS + 1);
  localparam int unsigned SEL_W      = $clog2(CTX_WORDS);

  typedef enum logic [1:0] {
    ALG_MD5    = 2'b00,
    ALG_SHA1   = 2'b01,
    ALG_SHA224 = 2'b10,
    ALG_SHA256 = 2'b11
  } alg_e;

  localparam logic [ADDR_W-1:0] ADR_MODE  = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_DSIZE = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_EOM   = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_CTX0  = 4'd4;

  function automatic logic [WORD_W-1:0] bswap32(input logic [WORD_W-1:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [DSIZE_W-1:0] clamp_dsize(input logic [WORD_W-1:0] v);
    if (v > WORD_W'(BLOCK_BITS)) return DSIZE_W'(BLOCK_BITS);
    return v[DSIZE_W-1:0];
  endfunction

  // First five standard chaining values, held in core (big-endian) order.
  function automatic logic [WORD_W-1:0] iv_word(input alg_e alg, input int unsigned idx);
    logic [WORD_W-1:0] w;
    w = '0;
    case (alg)
      ALG_MD5, ALG_SHA1: begin
        case (idx)
          0: w = 32'h67452301;
          1: w = 32'hefcdab89;
          2: w = 32'h98badcfe;
          3: w = 32'h10325476;
          4: w = (alg == ALG_SHA1) ? 32'hc3d2e1f0 : 32'h0;
          default: w = '0;
        endcase
      end
      ALG_SHA224: begin
        case (idx)
          0: w = 32'hc1059ed8;
          1: w = 32'h367cd507;
          2: w = 32'h3070dd17;
          3: w = 32'hf70e5939;
          4: w = 32'hffc00b31;
          default: w = '0;
        endcase
      end
      default: begin
        case (idx)
          0: w = 32'h6a09e667;
          1: w = 32'hbb67ae85;
          2: w = 32'h3c6ef372;
          3: w = 32'ha54ff53a;
          4: w = 32'h510e527f;
          default: w = '0;
        endcase
      end
    endcase
    return w;
  endfunction
endpackage

// File: rtl/hctx_core_stub.sv
module hctx_core_stub #(
  parameter int unsigned LATENCY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic finish
);
  localparam int unsigned CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

  logic [CNT_W-1:0] remain;

  assign finish = busy && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      remain <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      done   <= 1'b0;
      remain <= CNT_LOAD;
    end else if (finish) begin
      busy <= 1'b0;
      done <= 1'b1;
    end else if (busy) begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/hctx_ctx_file.sv
module hctx_ctx_file
  import hctx_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              init_load,
  input  alg_e                              init_alg,
  input  logic                              wr_en,
  input  logic [SEL_W-1:0]                  wr_sel,
  input  logic [WORD_W-1:0]                 wr_data,
  input  logic                              add_en,
  input  logic [DSIZE_W-1:0]                add_bits,
  output logic [HASH_WORDS-1:0][WORD_W-1:0] hash_q,
  output logic [2*WORD_W-1:0]               count_q
);
  localparam logic [SEL_W-1:0] SEL_CNT_LO = SEL_W'(HASH_WORDS);
  localparam logic [SEL_W-1:0] SEL_CNT_HI = SEL_W'(HASH_WORDS + 1);

  for (genvar g = 0; g < HASH_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              hash_q[g] <= '0;
      else if (init_load)                      hash_q[g] <= iv_word(init_alg, g);
      else if (wr_en && wr_sel == SEL_W'(g))   hash_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            count_q <= '0;
    else if (init_load)                    count_q <= '0;
    else if (wr_en && wr_sel == SEL_CNT_LO) count_q[WORD_W-1:0] <= wr_data;
    else if (wr_en && wr_sel == SEL_CNT_HI) count_q[2*WORD_W-1:WORD_W] <= wr_data;
    else if (add_en)                       count_q <= count_q + (2*WORD_W)'(add_bits);
  end
endmodule

// File: rtl/hash_ctx_regs.sv
module hash_ctx_regs
  import hctx_pkg::*;
#(
  parameter int unsigned LATENCY = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              err_irq,
  output logic              done
);
  alg_e                              mode_alg;
  logic [DSIZE_W-1:0]                dsize_q;
  logic [HASH_WORDS-1:0][WORD_W-1:0] hash_q;
  logic [2*WORD_W-1:0]               count_q;
  logic                              core_busy;
  logic                              core_finish;

  // Named internal events.
  logic             is_ctx;
  logic [SEL_W-1:0] ctx_sel;
  logic             is_hash;
  logic             swap_on;
  logic             eom_fire;
  logic             init_fire;
  logic             ctx_wr;
  logic             ctx_rd_bad;
  logic             rd_eom;
  logic [WORD_W-1:0] ctx_wr_data;
  logic [WORD_W-1:0] rd_mux;

  assign is_ctx     = (bus_addr >= ADR_CTX0) && (bus_addr < ADR_CTX0 + ADDR_W'(CTX_WORDS));
  assign ctx_sel    = SEL_W'(bus_addr - ADR_CTX0);
  assign is_hash    = is_ctx && (ctx_sel < SEL_W'(HASH_WORDS));
  assign swap_on    = is_hash && (mode_alg == ALG_MD5);
  assign eom_fire   = bus_wr && (bus_addr == ADR_EOM);
  assign init_fire  = bus_wr && (bus_addr == ADR_MODE) && bus_wdata[2];
  assign ctx_wr     = bus_wr && is_ctx;
  assign ctx_rd_bad = bus_rd && is_ctx && !done;
  assign rd_eom     = bus_rd && (bus_addr == ADR_EOM);
  assign ctx_wr_data = swap_on ? bswap32(bus_wdata) : bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_alg <= ALG_MD5;
      dsize_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADR_MODE)  mode_alg <= alg_e'(bus_wdata[1:0]);
      if (bus_addr == ADR_DSIZE) dsize_q  <= clamp_dsize(bus_wdata);
    end
  end

  hctx_core_stub #(.LATENCY(LATENCY)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (eom_fire),
    .busy   (core_busy),
    .done   (done),
    .finish (core_finish)
  );

  hctx_ctx_file u_ctx (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_load (init_fire),
    .init_alg  (alg_e'(bus_wdata[1:0])),
    .wr_en     (ctx_wr),
    .wr_sel    (ctx_sel),
    .wr_data   (ctx_wr_data),
    .add_en    (core_finish),
    .add_bits  (dsize_q),
    .hash_q    (hash_q),
    .count_q   (count_q)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADR_MODE) begin
      rd_mux = {{(WORD_W-2){1'b0}}, mode_alg};
    end else if (bus_addr == ADR_DSIZE) begin
      rd_mux = WORD_W'(dsize_q);
    end else if (is_ctx && done) begin
      if (is_hash)
        rd_mux = swap_on ? bswap32(hash_q[ctx_sel]) : hash_q[ctx_sel];
      else if (ctx_sel == SEL_W'(HASH_WORDS))
        rd_mux = count_q[WORD_W-1:0];
      else
        rd_mux = count_q[2*WORD_W-1:WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      err_irq   <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      err_irq <= ctx_rd_bad;
    end
  end
endmodule

// File: rtl/hctx_checker.sv
module hctx_checker
  import hctx_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                eom_fire,
  input logic                init_fire,
  input logic                ctx_rd_bad,
  input logic                rd_eom,
  input logic                core_busy,
  input logic                core_finish,
  input logic                done,
  input logic                err_irq,
  input logic [DSIZE_W-1:0]  dsize_q,
  input logic [2*WORD_W-1:0] count_q
);
  AST_ERR_FROM_BAD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> $past(ctx_rd_bad)); // R4
  AST_BAD_READ_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_rd_bad |-> !done); // R4
  AST_DONE_WITH_DATA_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !eom_fire) |=> !err_irq); // R5
  AST_TRIGGER_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    eom_fire |=> (!done && core_busy)); // R6
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !eom_fire) |=> done); // R6
  AST_FINISH_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (core_finish && !eom_fire) |=> done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && core_busy)); // R6
  AST_EOM_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rd_eom |=> !err_irq); // R7
  AST_INIT_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    init_fire |=> (count_q == '0)); // R8
  AST_DSIZE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dsize_q <= DSIZE_W'(BLOCK_BITS)); // R9
endmodule

bind hash_ctx_regs hctx_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .eom_fire    (eom_fire),
  .init_fire   (init_fire),
  .ctx_rd_bad  (ctx_rd_bad),
  .rd_eom      (rd_eom),
  .core_busy   (core_busy),
  .core_finish (core_finish),
  .done        (done),
  .err_irq     (err_irq),
  .dsize_q     (dsize_q),
  .count_q     (count_q)
);

// File: tb/sim_hash_ctx_regs.sv
module sim_hash_ctx_regs;
  localparam int unsigned LAT = 8;
  localparam int unsigned NV  = 39;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_WAIT = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        err_irq, done;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk; // 50 MHz

  hash_ctx_regs #(.LATENCY(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .err_irq(err_irq), .done(done)
  );

  // {req, op, addr, data, expected}
  localparam logic [73:0] VEC [NV] = '{
    {4'd10, OP_W,    4'd0,  32'h1,        32'h0},        // R10 select SHA-1
    {4'd9,  OP_W,    4'd1,  32'h40,       32'h0},        // R9
    {4'd6,  OP_W,    4'd2,  32'hDEADBEEF, 32'h0},        // R6 trigger
    {4'd6,  OP_WAIT, 4'd0,  32'h0,        32'h0},        // R6
    {4'd10, OP_R,    4'd0,  32'h0,        32'h1},        // R10
    {4'd9,  OP_R,    4'd1,  32'h0,        32'h40},       // R9
    {4'd9,  OP_R,    4'd9,  32'h0,        32'h40},       // R9 count grew
    {4'd9,  OP_R,    4'd10, 32'h0,        32'h0},        // R9
    {4'd2,  OP_W,    4'd4,  32'h11223344, 32'h0},        // R2
    {4'd2,  OP_R,    4'd4,  32'h0,        32'h11223344}, // R2
    {4'd3,  OP_W,    4'd0,  32'h0,        32'h0},        // R3 MD5
    {4'd3,  OP_R,    4'd4,  32'h0,        32'h44332211}, // R3 read swap
    {4'd3,  OP_W,    4'd5,  32'hA1B2C3D4, 32'h0},        // R3
    {4'd3,  OP_R,    4'd5,  32'h0,        32'hA1B2C3D4}, // R3 round trip
    {4'd3,  OP_W,    4'd0,  32'h3,        32'h0},        // R3 SHA-256
    {4'd3,  OP_R,    4'd5,  32'h0,        32'hD4C3B2A1}, // R3 write swap
    {4'd3,  OP_W,    4'd0,  32'h0,        32'h0},        // R3
    {4'd3,  OP_W,    4'd9,  32'h12345678, 32'h0},        // R3
    {4'd3,  OP_R,    4'd9,  32'h0,        32'h12345678}, // R3 count unswapped
    {4'd8,  OP_W,    4'd0,  32'h4,        32'h0},        // R8 init MD5
    {4'd8,  OP_R,    4'd4,  32'h0,        32'h01234567}, // R8
    {4'd8,  OP_R,    4'd7,  32'h0,        32'h76543210}, // R8
    {4'd8,  OP_R,    4'd8,  32'h0,        32'h0},        // R8
    {4'd8,  OP_R,    4'd9,  32'h0,        32'h0},        // R8 count cleared
    {4'd8,  OP_R,    4'd0,  32'h0,        32'h0},        // R8 init reads 0
    {4'd8,  OP_W,    4'd0,  32'h7,        32'h0},        // R8 init SHA-256
    {4'd8,  OP_R,    4'd4,  32'h0,        32'h6a09e667}, // R8
    {4'd8,  OP_R,    4'd8,  32'h0,        32'h510e527f}, // R8
    {4'd10, OP_R,    4'd0,  32'h0,        32'h3},        // R10
    {4'd8,  OP_W,    4'd0,  32'h5,        32'h0},        // R8 init SHA-1
    {4'd8,  OP_R,    4'd8,  32'h0,        32'hc3d2e1f0}, // R8
    {4'd8,  OP_W,    4'd0,  32'h6,        32'h0},        // R8 init SHA-224
    {4'd8,  OP_R,    4'd4,  32'h0,        32'hc1059ed8}, // R8
    {4'd7,  OP_R,    4'd2,  32'h0,        32'h0},        // R7
    {4'd11, OP_R,    4'd15, 32'h0,        32'h0},        // R11
    {4'd11, OP_R,    4'd3,  32'h0,        32'h0},        // R11
    {4'd10, OP_W,    4'd0,  32'hFFFFFFF9, 32'h0},        // R10 upper bits ignored
    {4'd10, OP_R,    4'd0,  32'h0,        32'h1},        // R10
    {4'd10, OP_R,    4'd4,  32'h0,        32'hc1059ed8}  // R10 no init
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_read(input logic [3:0] a, input logic [31:0] exp, input logic exp_err, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(bus_rdata == exp, req, bus_rdata, exp);
    check(err_irq == exp_err, req, 32'(err_irq), 32'(exp_err));
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    check(done == 1'b1, req, 32'(done), 32'h1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state at the ports
    check(done == 1'b0 && err_irq == 1'b0 && bus_rdata == '0, "R1",
          {bus_rdata[29:0], done, err_irq}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq; logic [1:0] op; logic [3:0] ad; logic [31:0] dv, ev;
      {rq, op, ad, dv, ev} = VEC[i];
      if (op == OP_W)         do_write(ad, dv);
      else if (op == OP_WAIT) wait_done($sformatf("R%0d", rq));
      else                    do_read(ad, ev, 1'b0, $sformatf("R%0d/R5", rq));
    end

    // Directed: fresh reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && err_irq == 1'b0 && bus_rdata == '0, "R1",
          {bus_rdata[29:0], done, err_irq}, 32'h0);
    rst_n = 1'b1;
    do_read(4'd0, 32'h0, 1'b0, "R1");
    do_read(4'd1, 32'h0, 1'b0, "R1");
    do_read(4'd4, 32'h0, 1'b1, "R4");        // before done: zero + error
    @(negedge clk);
    check(err_irq == 1'b0, "R4", 32'(err_irq), 32'h0); // one cycle only

    // Trigger timing, MD5 round trip after reset
    do_write(4'd4, 32'h00000055);
    do_write(4'd2, 32'hFFFFFFFF);            // R6: data ignored
    repeat (LAT - 1) @(negedge clk);
    check(done == 1'b0, "R6", 32'(done), 32'h0);
    @(negedge clk);
    check(done == 1'b1, "R6", 32'(done), 32'h1);
    do_read(4'd4, 32'h00000055, 1'b0, "R3");
    do_read(4'd5, 32'h0, 1'b0, "R1");
    do_read(4'd9, 32'h0, 1'b0, "R1");
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R6", 32'(done), 32'h1); // held

    // Clamp, retrigger while done, read during busy
    do_write(4'd1, 32'h0000FFFF);
    do_read(4'd1, 32'd512, 1'b0, "R9");
    do_write(4'd2, 32'h0);
    check(done == 1'b0, "R6", 32'(done), 32'h0);
    do_read(4'd4, 32'h0, 1'b1, "R4");
    do_read(4'd2, 32'h0, 1'b0, "R7");
    wait_done("R6");
    do_read(4'd9, 32'd512, 1'b0, "R9");

    // Carry into the high count word
    do_write(4'd9, 32'hFFFFFF00);
    do_write(4'd10, 32'h00000001);
    do_write(4'd1, 32'h100);
    do_write(4'd2, 32'h0);
    wait_done("R9");
    do_read(4'd9, 32'h0, 1'b0, "R9");
    do_read(4'd10, 32'h2, 1'b0, "R9");

    // R11: data appears only after the edge
    @(negedge clk); bus_rd = 1'b1; bus_addr = 4'd1;
    check(bus_rdata == 32'h2, "R11", bus_rdata, 32'h2);
    @(negedge clk); bus_rd = 1'b0;
    check(bus_rdata == 32'h100, "R11", bus_rdata, 32'h100);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule